// File: doc/BRIEF.md
# DRAM Self-Refresh Sleep/Wake Sequencer

This block is the memory controller's power-down manager for an asynchronous DRAM. When a sleep request arrives, it lowers the column strobe first and then the row strobe. This puts the memory into its self-maintained retention state. Both strobes are then held low for at least a programmable minimum time. During that time the device refreshes itself from its own row counter, so the block drives no address.

A wake request is honoured only after that minimum time has passed. On wake, the block releases both strobes and holds them high for an exit hold time. It then runs a complete burst of column-before-row refresh cycles, one for every row, before it hands the memory back to the normal access path.

The write strobe stays high throughout, so a refresh cycle can never be decoded as a test-mode entry. All timings are cycle counts of the system clock. A busy flag covers the whole excursion, and a handoff enable tells the access sequencer when it may drive the memory again.

Top module: `dram_sref_seq`

## Requirements
- R1: After reset, rasN, casN and weN are high, busy, sleepAck and wakeAck are low, and accessEn is high.
- R2: A sleepReq sampled while idle drives casN low with rasN high for exactly ENTRY_CYC cycles, and only then drives rasN low (column strobe before row strobe).
- R3: After the entry phase, rasN and casN stay low together for exactly SELF_MIN_CYC cycles with sleepAck low. Then sleepAck goes high with both strobes still low. A wakeReq during the entry or minimum phase is ignored.
- R4: A wakeReq sampled while sleepAck is high raises both strobes and holds them high for exactly EXIT_HOLD_CYC cycles.
- R5: After the exit hold, the block issues exactly ROW_COUNT refresh cycles. Each cycle is casN low with rasN high for SETUP_CYC cycles, then both low for RAS_LOW_CYC cycles, then both high for PRECH_CYC cycles.
- R6: weN is high in every cycle, including every refresh cycle the block issues.
- R7: busy is high from the cycle after sleepReq is accepted through the last precharge cycle of the burst. accessEn is always the inverse of busy.
- R8: wakeAck is high for exactly one cycle: the first idle cycle after the burst completes.
- R9: A sleepReq sampled while busy has no effect on the strobes or the sequence. A wakeReq sampled while idle leaves the strobes high and busy low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sleepReq | input | 1 | Request to enter self-refresh (sampled while idle) |
| wakeReq | input | 1 | Request to leave self-refresh (sampled while sleepAck is high) |
| rasN | output | 1 | Row strobe to the DRAM, active low, registered |
| casN | output | 1 | Column strobe to the DRAM, active low, registered |
| weN | output | 1 | Write strobe to the DRAM, held high |
| busy | output | 1 | Sequence in progress |
| accessEn | output | 1 | Handoff: the normal access path may drive the DRAM |
| sleepAck | output | 1 | Self-refresh minimum time has elapsed; wake may be requested |
| wakeAck | output | 1 | One-cycle pulse when the post-exit burst has finished |

## Verification
The embedded properties assume that the strobes change only because this block moves them. They also assume that every timing count is at least one, so each phase lasts at least a cycle. This lets a falling row strobe always be preceded by a low column strobe.

The bench drives requests only at falling clock edges and uses a small configuration with all counts at least one. It holds wakeReq high early or late, and it holds sleepReq high during the exit phase, so that the "ignored" cases still follow the handshake protocol the properties rely on. It sweeps the wake delay after sleepAck across a range. For every phase it checks run lengths that it derives arithmetically from the parameters.

// File: rtl/sref_pkg.sv
package sref_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ENTRY,
    ST_HOLD,
    ST_PARK,
    ST_EXIT,
    ST_CSETUP,
    ST_CLOW,
    ST_CPRECH
  } seqState_e;

  typedef enum logic [2:0] {
    TSEL_ENTRY,
    TSEL_SELF,
    TSEL_EXIT,
    TSEL_SETUP,
    TSEL_LOW,
    TSEL_PRECH
  } timerSel_e;

  typedef struct packed {
    logic      load;
    timerSel_e sel;
    logic      rowClr;
    logic      rowInc;
  } dpStrobe_t;

  function automatic int unsigned maxOf(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sref_datapath.sv
module sref_datapath
  import sref_pkg::*;
#(
  parameter int unsigned ENTRY_CYC    = 2,
  parameter int unsigned SELF_MIN_CYC = 5000,
  parameter int unsigned EXIT_HOLD_CYC = 10,
  parameter int unsigned ROW_COUNT    = 4096,
  parameter int unsigned SETUP_CYC    = 1,
  parameter int unsigned RAS_LOW_CYC  = 5,
  parameter int unsigned PRECH_CYC    = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  dpStrobe_t strobe,
  output logic      timerZero,
  output logic      rowLast
);

  localparam int unsigned MAX_LEN =
    maxOf(maxOf(maxOf(ENTRY_CYC, SELF_MIN_CYC), maxOf(EXIT_HOLD_CYC, SETUP_CYC)),
          maxOf(RAS_LOW_CYC, PRECH_CYC));
  localparam int unsigned TW = $clog2(MAX_LEN + 1);
  localparam int unsigned RW = (ROW_COUNT > 1) ? $clog2(ROW_COUNT) : 1;

  logic [TW-1:0] timer;
  logic [RW-1:0] rowCnt;
  int unsigned   loadLen;

  always_comb begin
    case (strobe.sel)
      TSEL_ENTRY: loadLen = ENTRY_CYC;
      TSEL_SELF:  loadLen = SELF_MIN_CYC;
      TSEL_EXIT:  loadLen = EXIT_HOLD_CYC;
      TSEL_SETUP: loadLen = SETUP_CYC;
      TSEL_LOW:   loadLen = RAS_LOW_CYC;
      default:    loadLen = PRECH_CYC;
    endcase
  end

  // Phase timer: loaded with length-1, so a phase spans exactly its length.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      timer <= '0;
    end else if (strobe.load) begin
      timer <= TW'(loadLen - 1);
    end else if (timer != '0) begin
      timer <= timer - TW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.rowClr) begin
      rowCnt <= '0;
    end else if (strobe.rowInc) begin
      rowCnt <= rowCnt + RW'(1);
    end
  end

  assign timerZero = (timer == '0);
  assign rowLast   = (rowCnt == RW'(ROW_COUNT - 1));

  // R5
  row_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rowInc |-> !rowLast);

endmodule

// File: rtl/sref_ctrl.sv
module sref_ctrl
  import sref_pkg::*;
#(
  parameter int unsigned SELF_MIN_CYC = 5000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sleepReq,
  input  logic      wakeReq,
  input  logic      timerZero,
  input  logic      rowLast,
  output dpStrobe_t strobe,
  output logic      rasN,
  output logic      casN,
  output logic      busy,
  output logic      sleepAck,
  output logic      wakeAck
);

  seqState_e state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '{load: 1'b0, sel: TSEL_ENTRY, rowClr: 1'b0, rowInc: 1'b0};
    case (state)
      ST_IDLE: if (sleepReq) begin
        stateNext = ST_ENTRY;
        strobe.load = 1'b1;
        strobe.sel  = TSEL_ENTRY;
      end
      ST_ENTRY: if (timerZero) begin
        stateNext = ST_HOLD;
        strobe.load = 1'b1;
        strobe.sel  = TSEL_SELF;
      end
      ST_HOLD: if (timerZero) stateNext = ST_PARK;
      ST_PARK: if (wakeReq) begin
        stateNext = ST_EXIT;
        strobe.load   = 1'b1;
        strobe.sel    = TSEL_EXIT;
        strobe.rowClr = 1'b1;
      end
      ST_EXIT: if (timerZero) begin
        stateNext = ST_CSETUP;
        strobe.load = 1'b1;
        strobe.sel  = TSEL_SETUP;
      end
      ST_CSETUP: if (timerZero) begin
        stateNext = ST_CLOW;
        strobe.load = 1'b1;
        strobe.sel  = TSEL_LOW;
      end
      ST_CLOW: if (timerZero) begin
        stateNext = ST_CPRECH;
        strobe.load = 1'b1;
        strobe.sel  = TSEL_PRECH;
      end
      ST_CPRECH: if (timerZero) begin
        if (rowLast) begin
          stateNext = ST_IDLE;
        end else begin
          stateNext = ST_CSETUP;
          strobe.load   = 1'b1;
          strobe.sel    = TSEL_SETUP;
          strobe.rowInc = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // Pins are registered from the next state so they never glitch.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      rasN     <= 1'b1;
      casN     <= 1'b1;
      busy     <= 1'b0;
      sleepAck <= 1'b0;
      wakeAck  <= 1'b0;
    end else begin
      state    <= stateNext;
      rasN     <= !(stateNext inside {ST_HOLD, ST_PARK, ST_CLOW});
      casN     <= !(stateNext inside {ST_ENTRY, ST_HOLD, ST_PARK, ST_CSETUP, ST_CLOW});
      busy     <= (stateNext != ST_IDLE);
      sleepAck <= (stateNext == ST_PARK);
      wakeAck  <= (state == ST_CPRECH) && (stateNext == ST_IDLE);
    end
  end

  // Checker state: consecutive cycles with both strobes low.
  localparam int unsigned LW = $clog2(SELF_MIN_CYC + 2);
  logic [LW-1:0] lowRun;
  always_ff @(posedge clk) begin
    if (!rstN || rasN || casN) begin
      lowRun <= '0;
    end else if (lowRun != LW'(SELF_MIN_CYC + 1)) begin
      lowRun <= lowRun + LW'(1);
    end
  end

  // R2
  cas_before_ras_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> $past(!casN));
  // R3
  self_min_chk: assert property (@(posedge clk) disable iff (!rstN)
    sleepAck |-> (lowRun >= LW'(SELF_MIN_CYC)));
  // R7
  ack_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    sleepAck |-> busy);
  // R8
  wake_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakeAck |-> (!busy && $past(busy)));
  // R8
  wake_ack_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakeAck |=> !wakeAck);

endmodule

// File: rtl/dram_sref_seq.sv
module dram_sref_seq
  import sref_pkg::*;
#(
  parameter int unsigned ENTRY_CYC     = 2,
  parameter int unsigned SELF_MIN_CYC  = 5000,
  parameter int unsigned EXIT_HOLD_CYC = 10,
  parameter int unsigned ROW_COUNT     = 4096,
  parameter int unsigned SETUP_CYC     = 1,
  parameter int unsigned RAS_LOW_CYC   = 5,
  parameter int unsigned PRECH_CYC     = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic sleepReq,
  input  logic wakeReq,
  output logic rasN,
  output logic casN,
  output logic weN,
  output logic busy,
  output logic accessEn,
  output logic sleepAck,
  output logic wakeAck
);

  dpStrobe_t strobe;
  logic      timerZero;
  logic      rowLast;

  sref_ctrl #(.SELF_MIN_CYC(SELF_MIN_CYC)) ctrl_i (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .wakeReq(wakeReq),
    .timerZero(timerZero), .rowLast(rowLast), .strobe(strobe),
    .rasN(rasN), .casN(casN), .busy(busy), .sleepAck(sleepAck), .wakeAck(wakeAck)
  );

  sref_datapath #(
    .ENTRY_CYC(ENTRY_CYC), .SELF_MIN_CYC(SELF_MIN_CYC), .EXIT_HOLD_CYC(EXIT_HOLD_CYC),
    .ROW_COUNT(ROW_COUNT), .SETUP_CYC(SETUP_CYC), .RAS_LOW_CYC(RAS_LOW_CYC),
    .PRECH_CYC(PRECH_CYC)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .timerZero(timerZero), .rowLast(rowLast)
  );

  // Write strobe never drops, so no refresh cycle can look like a test-mode entry.
  assign weN      = 1'b1;
  assign accessEn = !busy;

endmodule

// File: tb/dram_sref_seq_tb_top.sv
module dram_sref_seq_tb_top;

  localparam int unsigned ENTRY = 2;
  localparam int unsigned SMIN  = 20;
  localparam int unsigned EXITH = 3;
  localparam int unsigned ROWS  = 8;
  localparam int unsigned SETUP = 1;
  localparam int unsigned RLOW  = 3;
  localparam int unsigned PRECH = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sleepReq = 1'b0;
  logic wakeReq = 1'b0;
  logic rasN, casN, weN, busy, accessEn, sleepAck, wakeAck;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  dram_sref_seq #(
    .ENTRY_CYC(ENTRY), .SELF_MIN_CYC(SMIN), .EXIT_HOLD_CYC(EXITH), .ROW_COUNT(ROWS),
    .SETUP_CYC(SETUP), .RAS_LOW_CYC(RLOW), .PRECH_CYC(PRECH)
  ) dut_i (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .wakeReq(wakeReq),
    .rasN(rasN), .casN(casN), .weN(weN), .busy(busy), .accessEn(accessEn),
    .sleepAck(sleepAck), .wakeAck(wakeAck)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // Checks n consecutive cycles (sampled at falling edges) against one pin pattern.
  task automatic expectRun(input logic eRas, input logic eCas, input logic eAck,
                           input logic eBusy, input int n, input string tag);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      if (rasN !== eRas || casN !== eCas || weN !== 1'b1 || sleepAck !== eAck ||
          busy !== eBusy || accessEn !== !eBusy || wakeAck !== 1'b0) begin
        if (bad == 0)
          $display("FAIL %s cycle %0d: ras/cas/we/ack/busy/en/wack=%b%b%b%b%b%b%b exp %b%b1%b%b%b0",
                   tag, i, rasN, casN, weN, sleepAck, busy, accessEn, wakeAck,
                   eRas, eCas, eAck, eBusy, !eBusy);
        bad++;
      end
      @(negedge clk);
    end
    checks++;
    if (bad != 0) errors++;
  endtask

  task automatic sleepWake(input int extraPark, input bit earlyWake, input bit sleepInBurst);
    sleepReq = 1'b1;
    wakeReq  = earlyWake;
    @(negedge clk);
    sleepReq = 1'b0;
    expectRun(1, 0, 0, 1, ENTRY, "R2/R6 entry");
    expectRun(0, 0, 0, 1, SMIN, "R3 self minimum");
    for (int d = 0; d <= extraPark; d++) begin
      checks++;
      if (rasN !== 1'b0 || casN !== 1'b0 || sleepAck !== 1'b1 || busy !== 1'b1) begin
        errors++;
        $display("FAIL R3 park cycle %0d: ras/cas/ack/busy=%b%b%b%b exp 0011",
                 d, rasN, casN, sleepAck, busy);
      end
      if (d == extraPark) wakeReq = 1'b1;
      @(negedge clk);
    end
    wakeReq  = 1'b0;
    sleepReq = sleepInBurst;
    expectRun(1, 1, 0, 1, EXITH, "R4 exit hold / R9 sleep while busy");
    sleepReq = 1'b0;
    for (int r = 0; r < int'(ROWS); r++) begin
      expectRun(1, 0, 0, 1, SETUP, "R5/R6 cbr setup");
      expectRun(0, 0, 0, 1, RLOW, "R5 cbr ras low");
      expectRun(1, 1, 0, 1, PRECH, "R5 cbr precharge");
    end
    checks++;
    if (busy !== 1'b0 || accessEn !== 1'b1 || wakeAck !== 1'b1 || rasN !== 1'b1 || casN !== 1'b1) begin
      errors++;
      $display("FAIL R7/R8 handoff: busy/en/wack/ras/cas=%b%b%b%b%b exp 01111",
               busy, accessEn, wakeAck, rasN, casN);
    end
    @(negedge clk);
    checks++;
    if (wakeAck !== 1'b0 || busy !== 1'b0) begin
      errors++;
      $display("FAIL R8 pulse width: wack/busy=%b%b exp 00", wakeAck, busy);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    expectRun(1, 1, 0, 0, 2, "R1 reset");
    // R9 wake while idle
    wakeReq = 1'b1;
    @(negedge clk);
    expectRun(1, 1, 0, 0, 4, "R9 wake while idle");
    wakeReq = 1'b0;
    @(negedge clk);
    // R3 early wake held through entry and minimum
    sleepWake(0, 1'b1, 1'b0);
    // sweep of wake delays after sleepAck, R4 R5
    for (int d = 0; d < 7; d++) begin
      sleepWake(d, 1'b0, (d % 2) == 1);
      repeat (d) @(negedge clk);
    end
    expectRun(1, 1, 0, 0, 3, "R1/R7 idle after sweep");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule